// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls a port of general-purpose pins, eight by default. Software uses a single-cycle register bus with an address, a write enable, write data and registered read data. Through it, software can latch output values, choose the direction of each pin and enable pull-ups. It can also force chosen latch bits high with a set-only register, so there is no read-modify-write sequence that could race with other code.

Each pin has its own pad signals: the output value, the output enable, the pull-up enable and the raw input level. The raw input passes through a two-stage synchronizer before the logic uses it. A read of the data register gives a per-bit mix. Bits configured as outputs return the latched value, and bits configured as inputs return the synchronized pin level.

An asynchronous active-low reset clears all state at once. Its release is synchronized to the clock inside the block.

Top module: `gpio_port`

## Requirements
- R1: While reset is held and after reset, the data latch, direction and pull-up registers are all zero: pad_oe, pad_pu and pad_out are 0, and reads of the direction and pull-up registers return 0.
- R2: A write to address 0 (data latch) stores all bits of wdata in the latch whatever each bit's direction. The new value appears on pad_out after the clock edge that takes the write. Cycles without a write leave every register unchanged.
- R3: A write to address 1 (direction) sets pad_oe to wdata after the same edge. Bit value 1 means the pin drives its latch bit and bit value 0 means the pin is an input.
- R4: A read of address 0 returns, for each bit, the latch bit when the direction bit is 1 and the synchronized pin level when it is 0.
- R5: A read of address 1 returns the direction value last written.
- R6: A write to address 2 (set) turns each latch bit whose wdata bit is 1 into 1 and leaves latch bits whose wdata bit is 0 unchanged.
- R7: A read of address 2 always returns zero.
- R8: A change on pad_in shows in data reads only after two synchronizer stages. With the pin changed before clock edge 1, the reads captured at edges 1 and 2 give the old level and the read captured at edge 3 gives the new level.
- R9: A write to address 3 (pull-up) sets pad_pu after the same edge, and a read of address 3 returns it.
- R10: Asserting rst_n low clears pad_oe, pad_pu and pad_out at once, without waiting for a clock edge.
- R11: rdata is registered. It shows the register selected by addr during the cycle before the clock edge, captured at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| addr | input | 2 | Register select: 0 latch, 1 direction, 2 set, 3 pull-up |
| we | input | 1 | Write enable for the selected register |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Registered read data |
| pad_in | input | WIDTH | Raw pin levels from the pads |
| pad_out | output | WIDTH | Output value for each pin |
| pad_oe | output | WIDTH | Output driver enable for each pin |
| pad_pu | output | WIDTH | Pull-up enable for each pin |

## Verification
Register writes reach pad_out, pad_oe and pad_pu after the single edge that takes the write. The bench therefore drives a write half a cycle before that edge and samples the pads at the next falling edge. Read data comes one edge after the address is presented, so every read is sampled at the falling edge after its capturing edge. Pin changes need three edges before a data read can show them. The bench checks the exact edge count once and, in random traffic, waits two idle cycles after every pin change before reading. An asynchronous reset is checked one nanosecond after it asserts, away from any edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int GPIO_ADDR_W = 2;

  typedef enum logic [GPIO_ADDR_W-1:0] {
    REG_LATCH = 2'd0,
    REG_DIR   = 2'd1,
    REG_SET   = 2'd2,
    REG_PULL  = 2'd3
  } gpio_reg_e;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_raw,
  output logic [WIDTH-1:0] pin_safe
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = pin_raw;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d;
    end
  end

  assign pin_safe = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  gpio_reg_e        wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] pull_q
);
  logic [WIDTH-1:0] latch_d, dir_d, pull_d;
  logic             latch_en, dir_en, pull_en;

  // Write decode and next-state values
  always_comb begin
    latch_en = 1'b0;
    dir_en   = 1'b0;
    pull_en  = 1'b0;
    latch_d  = latch_q;
    dir_d    = dir_q;
    pull_d   = pull_q;
    if (wr_en) begin
      unique case (wr_sel)
        REG_LATCH: begin latch_en = 1'b1; latch_d = wr_data;           end
        REG_SET:   begin latch_en = 1'b1; latch_d = latch_q | wr_data; end
        REG_DIR:   begin dir_en   = 1'b1; dir_d   = wr_data;           end
        REG_PULL:  begin pull_en  = 1'b1; pull_d  = wr_data;           end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        latch_q <= '0;
    else if (latch_en) latch_q <= latch_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pull_q <= '0;
    else if (pull_en) pull_q <= pull_d;
  end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  gpio_reg_e        rd_sel,
  input  logic [WIDTH-1:0] latch_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] pull_q,
  input  logic [WIDTH-1:0] pin_safe,
  output logic [WIDTH-1:0] rd_q
);
  logic [WIDTH-1:0] mix;
  logic [WIDTH-1:0] rd_d;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign mix[b] = dir_q[b] ? latch_q[b] : pin_safe[b];
  end

  always_comb begin
    unique case (rd_sel)
      REG_LATCH: rd_d = mix;
      REG_DIR:   rd_d = dir_q;
      REG_PULL:  rd_d = pull_q;
      REG_SET:   rd_d = '0;
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [GPIO_ADDR_W-1:0] addr,
  input  logic                   we,
  input  logic [WIDTH-1:0]       wdata,
  output logic [WIDTH-1:0]       rdata,
  input  logic [WIDTH-1:0]       pad_in,
  output logic [WIDTH-1:0]       pad_out,
  output logic [WIDTH-1:0]       pad_oe,
  output logic [WIDTH-1:0]       pad_pu
);
  logic             core_rst_n;
  gpio_reg_e        sel;
  logic [WIDTH-1:0] latch_q, dir_q, pull_q, pin_safe;

  assign sel = gpio_reg_e'(addr);

  gpio_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(core_rst_n)
  );

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(core_rst_n), .pin_raw(pad_in), .pin_safe(pin_safe)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(core_rst_n), .wr_en(we), .wr_sel(sel), .wr_data(wdata),
    .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q)
  );

  gpio_read_mux #(.WIDTH(WIDTH)) u_rd (
    .clk(clk), .rst_n(core_rst_n), .rd_sel(sel), .latch_q(latch_q),
    .dir_q(dir_q), .pull_q(pull_q), .pin_safe(pin_safe), .rd_q(rdata)
  );

  assign pad_out = latch_q;
  assign pad_oe  = dir_q;
  assign pad_pu  = pull_q;
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_rst_n,
  input logic [1:0]       addr,
  input logic             we,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] rdata,
  input logic [WIDTH-1:0] pad_out,
  input logic [WIDTH-1:0] pad_oe,
  input logic [WIDTH-1:0] pad_pu
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && pad_pu == '0 && pad_out == '0)); // R1

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!core_rst_n)
    (we && addr == 2'd0) |=> pad_out == $past(wdata)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!core_rst_n)
    !we |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_pu))); // R2

  AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!core_rst_n)
    (we && addr == 2'd1) |=> pad_oe == $past(wdata)); // R3

  AST_SET_OR: assert property (@(posedge clk) disable iff (!core_rst_n)
    (we && addr == 2'd2) |=> pad_out == ($past(pad_out) | $past(wdata))); // R6

  AST_SET_READS_ZERO: assert property (@(posedge clk) disable iff (!core_rst_n)
    (addr == 2'd2) |=> rdata == '0); // R7

  AST_PULL_WRITE: assert property (@(posedge clk) disable iff (!core_rst_n)
    (we && addr == 2'd3) |=> pad_pu == $past(wdata)); // R9

  AST_DIR_READ: assert property (@(posedge clk) disable iff (!core_rst_n)
    (addr == 2'd1) |=> rdata == $past(pad_oe)); // R5
endmodule

bind gpio_port gpio_port_checker #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .core_rst_n(core_rst_n), .addr(addr), .we(we),
  .wdata(wdata), .rdata(rdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .pad_pu(pad_pu)
);

// File: tb/gpio_port_bench.sv
`timescale 1ns/1ps
module gpio_port_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [1:0]   addr;
  logic         we;
  logic [W-1:0] wdata, rdata, pad_in, pad_out, pad_oe, pad_pu;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  logic [W-1:0] m_latch, m_dir, m_pull, m_pin;

  always #2.5 clk = ~clk;

  gpio_port u_gpio_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu)
  );

  function automatic logic [W-1:0] exp_read(input logic [1:0] a);
    case (a)
      2'd0:    return (m_latch & m_dir) | (m_pin & ~m_dir);
      2'd1:    return m_dir;
      2'd3:    return m_pull;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic do_write(input logic [1:0] a, input logic [W-1:0] d);
    addr = a; we = 1'b1; wdata = d;
    @(posedge clk); @(negedge clk);
    we = 1'b0;
    case (a)
      2'd0: m_latch = d;
      2'd1: m_dir   = d;
      2'd2: m_latch = m_latch | d;
      default: m_pull = d;
    endcase
  endtask

  task automatic do_read(input logic [1:0] a, output logic [W-1:0] q);
    addr = a; we = 1'b0;
    @(posedge clk); @(negedge clk);
    q = rdata;
  endtask

  task automatic reset_model();
    m_latch = '0; m_dir = '0; m_pull = '0;
  endtask

  task automatic check_pads(input string req);
    check({req, " pad_out"}, pad_out, m_latch);
    check({req, " pad_oe"},  pad_oe,  m_dir);
    check({req, " pad_pu"},  pad_pu,  m_pull);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] q;
    void'($urandom(32'd2024));
    rst_n = 1'b0; addr = '0; we = 1'b0; wdata = '0; pad_in = 8'hFF;
    reset_model(); m_pin = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is held
    check_pads("R1 in reset");
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check_pads("R1 after reset");
    do_read(2'd1, q); check("R1 dir reset", q, 8'h00);
    do_read(2'd3, q); check("R1 pull reset", q, 8'h00);
    do_read(2'd0, q); check("R4 all inputs read pins", q, 8'hFF);

    // R2: latch write while all pins are inputs, then expose by direction
    do_write(2'd0, 8'hA5); check("R2 latch stored", pad_out, 8'hA5);
    check("R3 still inputs", pad_oe, 8'h00);
    do_write(2'd1, 8'h0F); check("R3 oe follows dir", pad_oe, 8'h0F);
    do_read(2'd0, q); check("R4 mixed read", q, 8'hF5);
    do_read(2'd1, q); check("R5 dir readback", q, 8'h0F);

    // R6/R7: set register
    do_write(2'd2, 8'h42); check("R6 set ors ones", pad_out, 8'hE7);
    do_write(2'd2, 8'h00); check("R6 zero set no effect", pad_out, 8'hE7);
    do_read(2'd2, q); check("R7 set reads zero", q, 8'h00);

    // R9: pull-ups
    do_write(2'd3, 8'h3C); check("R9 pad_pu", pad_pu, 8'h3C);
    do_read(2'd3, q); check("R9 pull readback", q, 8'h3C);

    // R8: synchronizer latency, all inputs
    do_write(2'd1, 8'h00);
    pad_in = 8'h5A;
    do_read(2'd0, q); check("R8 edge1 old", q, 8'hFF);
    do_read(2'd0, q); check("R8 edge2 old", q, 8'hFF);
    do_read(2'd0, q); check("R8 edge3 new", q, 8'h5A);
    m_pin = 8'h5A;

    // R11: read data registered, address switch takes one edge
    addr = 2'd3; #1; check("R11 rdata held before edge", rdata, 8'h5A);
    @(negedge clk); check("R11 rdata after edge", rdata, 8'h3C);

    // Random traffic
    for (int i = 0; i < 400; i++) begin
      logic [1:0]   a;
      logic [W-1:0] d;
      if ($urandom_range(0, 4) == 0) begin
        pad_in = W'($urandom);
        @(negedge clk); @(negedge clk);
        m_pin = pad_in;
      end
      a = 2'($urandom_range(0, 3));
      d = W'($urandom);
      if ($urandom_range(0, 1) == 1) begin
        do_write(a, d);
        check_pads("R2/R3/R6/R9 random write");
      end else begin
        do_read(a, q);
        check("R4/R5/R7 random read", q, exp_read(a));
      end
    end

    // R10: asynchronous reset assertion
    do_write(2'd1, 8'hFF); do_write(2'd0, 8'h99); do_write(2'd3, 8'h77);
    #1 rst_n = 1'b0;
    #1;
    reset_model();
    check_pads("R10 async clear");
    @(negedge clk); rst_n = 1'b1;
    repeat (6) @(negedge clk);
    do_read(2'd1, q); check("R1 dir after second reset", q, 8'h00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule